// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block sequences a 12-bit successive-approximation converter. It accepts a start request from one of four selectable sources: a software strobe, two periodic timer pulses, or an external pin. It then runs an optional track (sample) phase followed by a fixed convert phase. During the convert phase it drives a trial code towards the converter's DAC. It resolves one result bit per SAR clock from the single-bit comparator answer.

A mode field decides when the input is tracked. In post mode the sampler holds while idle and tracks only after a start, for a programmed number of SAR clocks. In pre mode the sampler tracks continuously while idle, and a start goes straight to conversion. Dual mode does both, so a minimum track time is guaranteed. All sequencing advances only on cycles where the SAR clock enable is high. At the end of each conversion a sticky done flag is raised, and it can drive an interrupt request. The analogue sampler, the input multiplexer and the reference are outside the block. The bench models the comparator as a digital stub.

Top module: `sar_conv_seq`

## Requirements
- R1: `src_sel` chooses the only source that can start a conversion: 0 = `sw_start`, 1 = `tmr_a_ovf`, 2 = `tmr_b_ovf`, 3 = rising edge of `ext_start`. Pulses on the other sources have no effect.
- R2: `ext_start` passes through two synchronising flops, and only its rising edge starts a conversion. The start is taken on the third clock edge after the pin rises. A level held high starts exactly one conversion.
- R3: In post mode (`trk_mode` = 0), `track` is low while idle. A start opens a track phase of `trk_len` enabled SAR clocks, with 0 treated as 1. The convert phase follows it.
- R4: In pre mode (`trk_mode` = 1), `track` is high while idle, and a start enters the convert phase directly with no track phase.
- R5: In dual mode (`trk_mode` = 2, and 3 behaves the same), `track` is high while idle and also during a post-start track phase of `trk_len` SAR clocks (0 treated as 1).
- R6: The convert phase lasts exactly 13 enabled SAR clocks, and `track` is low throughout it.
- R7: The result is resolved MSB first. Each trial code on `trial_code` is the bits kept so far plus the current bit set. That bit is kept when `cmp_ge` is 1. The final `code` equals the comparator's threshold input.
- R8: `done` is set on the clock edge that ends the convert phase, at the same edge where `busy` falls. It stays set until `done_clr` is applied, and a new completion wins over a simultaneous clear.
- R9: `irq` is high exactly when `done` is set and `irq_en` is 1.
- R10: A start request that arrives while `busy` is high is ignored and does not cause a further conversion.
- R11: While `sar_ce` is low, the track and convert phases do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Start source selector |
| trk_mode | input | 2 | Tracking mode: 0 post, 1 pre, 2/3 dual |
| trk_len | input | 4 | Post-start track length in SAR clocks (0 acts as 1) |
| irq_en | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software start strobe |
| tmr_a_ovf | input | 1 | First timer overflow pulse |
| tmr_b_ovf | input | 1 | Second timer overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| sar_ce | input | 1 | SAR clock enable |
| cmp_ge | input | 1 | Comparator: input at or above trial level |
| done_clr | input | 1 | Clears the done flag |
| trial_code | output | 12 | Trial code to the DAC |
| code | output | 12 | Last conversion result |
| track | output | 1 | 1 = sampler tracks, 0 = hold |
| busy | output | 1 | Track or convert phase in progress |
| done | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |

## Verification
With the SAR enable held high, a start from software or a timer taken at edge E sets `busy` one step after E. In pre mode `done` and `code` appear after edge E+13. In post and dual modes they appear after edge E+L+13, where L is the track length with 0 read as 1. An external start adds two more edges for the synchroniser. The bench counts edges from the start edge inclusively, so it expects 14, L+14 or 16. It samples one nanosecond after each rising edge and compares that count and the code at the first sample where `done` is high. `track` is sampled right after the start edge and again after completion. Ignored starts are checked by watching `busy` for several cycles after the stimulus.

// File: rtl/sar_conv_seq_pkg.sv
package sar_conv_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACK = 2'd1,
        PH_CONV  = 2'd2
    } phase_e;

    localparam logic [1:0] SRC_SOFT  = 2'd0;
    localparam logic [1:0] SRC_TMR_A = 2'd1;
    localparam logic [1:0] SRC_TMR_B = 2'd2;
    localparam logic [1:0] SRC_PIN   = 2'd3;

    localparam logic [1:0] MODE_POST = 2'd0;
    localparam logic [1:0] MODE_PRE  = 2'd1;
endpackage

// File: rtl/sar_conv_seq_start.sv
module sar_conv_seq_start
    import sar_conv_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sw_start,
    input  logic       tmr_a_ovf,
    input  logic       tmr_b_ovf,
    input  logic       ext_start,
    output logic       start_evt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } st_t;

    st_t st_d, st_q;
    logic pin_rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_start};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        pin_rise  = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
        unique case (src_sel)
            SRC_SOFT:  start_evt = sw_start;
            SRC_TMR_A: start_evt = tmr_a_ovf;
            SRC_TMR_B: start_evt = tmr_b_ovf;
            default:   start_evt = pin_rise;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sar_conv_seq_fsm.sv
module sar_conv_seq_fsm
    import sar_conv_seq_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int TRK_W    = 4,
    localparam int STEP_W  = $clog2(RES_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sar_ce,
    input  logic              start_evt,
    input  logic [1:0]        trk_mode,
    input  logic [TRK_W-1:0]  trk_len,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              track,
    output logic              busy,
    output logic              conv_load,
    output logic              resolve,
    output logic              finish
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RES_BITS);

    typedef struct packed {
        phase_e             phase;
        logic [TRK_W-1:0]   trk_cnt;
        logic [STEP_W-1:0]  step;
        logic               track;
    } st_t;

    st_t st_d, st_q;
    logic [TRK_W-1:0] len_eff;

    always_comb begin
        st_d      = st_q;
        len_eff   = (trk_len == '0) ? TRK_W'(1) : trk_len;
        resolve   = 1'b0;
        finish    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_evt) begin
                    st_d.step = '0;
                    if (trk_mode == MODE_PRE) begin
                        st_d.phase = PH_CONV;
                    end else begin
                        st_d.phase   = PH_TRACK;
                        st_d.trk_cnt = len_eff;
                    end
                end
            end
            PH_TRACK: begin
                if (sar_ce) begin
                    if (st_q.trk_cnt <= TRK_W'(1)) st_d.phase = PH_CONV;
                    else st_d.trk_cnt = st_q.trk_cnt - TRK_W'(1);
                end
            end
            default: begin
                if (sar_ce) begin
                    if (st_q.step == LAST_STEP) begin
                        finish     = 1'b1;
                        st_d.phase = PH_IDLE;
                    end else begin
                        resolve   = 1'b1;
                        st_d.step = st_q.step + STEP_W'(1);
                    end
                end
            end
        endcase
        st_d.track = (st_d.phase == PH_TRACK) ||
                     ((st_d.phase == PH_IDLE) && (trk_mode != MODE_POST));
        conv_load  = (st_q.phase != PH_CONV) && (st_d.phase == PH_CONV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, trk_cnt: '0, step: '0, track: 1'b0};
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign step  = st_q.step;
    assign track = st_q.track;
    assign busy  = st_q.phase != PH_IDLE;
endmodule

// File: rtl/sar_conv_seq_sar.sv
module sar_conv_seq_sar #(
    parameter int RES_BITS = 12,
    localparam int STEP_W  = $clog2(RES_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_load,
    input  logic                resolve,
    input  logic                finish,
    input  logic [STEP_W-1:0]   step,
    input  logic                cmp_ge,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result
);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        logic [RES_BITS-1:0] acc;
        logic [RES_BITS-1:0] result;
    } st_t;

    st_t st_d, st_q;
    logic [RES_BITS-1:0] bit_mask;

    always_comb begin
        st_d       = st_q;
        bit_mask   = MSB_ONE >> step;
        trial_code = st_q.acc | bit_mask;
        if (conv_load) begin
            st_d.acc = '0;
        end else if (resolve && cmp_ge) begin
            st_d.acc = trial_code;
        end
        if (finish) st_d.result = st_q.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.result;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_conv_seq_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int TRK_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          src_sel,
    input  logic [1:0]          trk_mode,
    input  logic [TRK_W-1:0]    trk_len,
    input  logic                irq_en,
    input  logic                sw_start,
    input  logic                tmr_a_ovf,
    input  logic                tmr_b_ovf,
    input  logic                ext_start,
    input  logic                sar_ce,
    input  logic                cmp_ge,
    input  logic                done_clr,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] code,
    output logic                track,
    output logic                busy,
    output logic                done,
    output logic                irq
);
    localparam int STEP_W = $clog2(RES_BITS + 1);

    logic              start_evt;
    phase_e            phase_w;
    logic [STEP_W-1:0] step_w;
    logic              conv_load, resolve, finish;
    logic              done_d, done_q;

    sar_conv_seq_start #(.SYNC_STAGES(SYNC_STAGES)) u_start (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_start(sw_start),
        .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf), .ext_start(ext_start),
        .start_evt(start_evt)
    );

    sar_conv_seq_fsm #(.RES_BITS(RES_BITS), .TRK_W(TRK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .start_evt(start_evt),
        .trk_mode(trk_mode), .trk_len(trk_len), .phase(phase_w), .step(step_w),
        .track(track), .busy(busy), .conv_load(conv_load), .resolve(resolve),
        .finish(finish)
    );

    sar_conv_seq_sar #(.RES_BITS(RES_BITS)) u_sar (
        .clk(clk), .rst_n(rst_n), .conv_load(conv_load), .resolve(resolve),
        .finish(finish), .step(step_w), .cmp_ge(cmp_ge),
        .trial_code(trial_code), .result(code)
    );

    always_comb begin
        done_d = finish | (done_q & ~done_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign done = done_q;
    assign irq  = done_q & irq_en;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sar_ce,
    input logic [1:0] trk_mode,
    input logic       done_clr,
    input logic       track,
    input logic       busy,
    input logic       done,
    input logic [1:0] phase
);
    assert_hold_during_convert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> !track);

    assert_post_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && trk_mode == 2'd0 && $stable(trk_mode)) |-> !track);

    assert_pre_idle_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && trk_mode == 2'd1 && $stable(trk_mode)) |-> track);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    assert_freeze_without_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sar_ce && busy) |=> $stable(phase));
endmodule

bind sar_conv_seq sar_conv_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .trk_mode(trk_mode),
    .done_clr(done_clr), .track(track), .busy(busy), .done(done),
    .phase(phase_w)
);

// File: tb/sar_conv_seq_tb.sv
`timescale 1ns/1ps
module sar_conv_seq_tb;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [1:0]  trk_mode = 2'd0;
    logic [3:0]  trk_len = 4'd0;
    logic        irq_en = 1'b0;
    logic        sw_start = 1'b0;
    logic        tmr_a_ovf = 1'b0;
    logic        tmr_b_ovf = 1'b0;
    logic        ext_start = 1'b0;
    logic        sar_ce = 1'b1;
    logic        cmp_ge;
    logic        done_clr = 1'b0;
    logic [11:0] trial_code, code;
    logic        track, busy, done, irq;
    logic [11:0] vin = 12'd0;
    logic        ce_off = 1'b0;
    logic        ce_alt = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign cmp_ge = (vin >= trial_code);

    always @(negedge clk) sar_ce <= ce_off ? 1'b0 : (ce_alt ? ~sar_ce : 1'b1);

    sar_conv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .trk_mode(trk_mode),
        .trk_len(trk_len), .irq_en(irq_en), .sw_start(sw_start),
        .tmr_a_ovf(tmr_a_ovf), .tmr_b_ovf(tmr_b_ovf), .ext_start(ext_start),
        .sar_ce(sar_ce), .cmp_ge(cmp_ge), .done_clr(done_clr),
        .trial_code(trial_code), .code(code), .track(track), .busy(busy),
        .done(done), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_done();
        done_clr = 1'b1;
        tick();
        done_clr = 1'b0;
    endtask

    // Pulse the chosen source, count edges (start edge = 1) until done
    task automatic run(input logic [1:0] src, output int lat, output logic trk_after_start);
        case (src)
            2'd0: sw_start = 1'b1;
            2'd1: tmr_a_ovf = 1'b1;
            2'd2: tmr_b_ovf = 1'b1;
            default: ext_start = 1'b1;
        endcase
        tick();
        sw_start = 1'b0; tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0;
        lat = 1;
        trk_after_start = track;
        while (!done && lat < 400) begin
            tick();
            lat++;
            if (lat == 3 && src == 2'd3) trk_after_start = track;
        end
    endtask

    task automatic idle_check(input int cycles, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            tick();
            if (busy) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    initial begin
        #(CLK_NS * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int   lat;
        logic ta;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state, post mode idle (R3)
        check(!busy && !done && !irq, "reset", {busy, done, irq}, 0);
        check(code == 12'd0, "reset code", code, 0);
        check(!track, "R3 post idle hold", track, 0);

        // Exhaustive sweep in pre mode (R4, R6, R7)
        trk_mode = 2'd1;
        tick();
        check(track, "R4 pre idle track", track, 1);
        for (int v = 0; v < 4096; v++) begin
            vin = 12'(v);
            run(2'd0, lat, ta);
            check(lat == 14, "R6 pre latency", lat, 14);
            check(code == 12'(v), "R7 code", code, v);
            if (v < 4) check(!ta, "R4 no track after start", ta, 0);
            clear_done();
        end

        // Post mode lengths (R3)
        trk_mode = 2'd0;
        vin = 12'd1234;
        for (int l = 0; l < 16; l += 5) begin
            int el;
            trk_len = 4'(l);
            el = (l == 0) ? 1 : l;
            tick();
            run(2'd0, lat, ta);
            check(lat == el + 14, "R3 post latency", lat, el + 14);
            check(ta, "R3 tracking after start", ta, 1);
            check(code == 12'd1234, "R7 post code", code, 1234);
            tick();
            check(!track, "R3 hold after completion", track, 0);
            clear_done();
        end

        // Dual mode and mode 3 (R5)
        for (int m = 2; m < 4; m++) begin
            trk_mode = 2'(m);
            trk_len = 4'd3;
            vin = 12'd4095;
            tick();
            check(track, "R5 dual idle track", track, 1);
            run(2'd0, lat, ta);
            check(lat == 17, "R5 dual latency", lat, 17);
            check(ta, "R5 track after start", ta, 1);
            check(code == 12'd4095, "R7 dual code", code, 4095);
            tick();
            check(track, "R5 track after completion", track, 1);
            clear_done();
        end

        // Source selection (R1)
        trk_mode = 2'd1;
        src_sel = 2'd1;
        vin = 12'd77;
        tick();
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        check(!busy, "R1 sw ignored when timer A selected", busy, 0);
        tmr_b_ovf = 1'b1; tick(); tmr_b_ovf = 1'b0;
        check(!busy, "R1 timer B ignored when timer A selected", busy, 0);
        run(2'd1, lat, ta);
        check(lat == 14 && code == 12'd77, "R1 timer A start", lat, 14);
        clear_done();
        src_sel = 2'd2;
        tick();
        tmr_a_ovf = 1'b1; tick(); tmr_a_ovf = 1'b0;
        check(!busy, "R1 timer A ignored when timer B selected", busy, 0);
        run(2'd2, lat, ta);
        check(lat == 14 && code == 12'd77, "R1 timer B start", lat, 14);
        clear_done();

        // External pin (R2)
        src_sel = 2'd3;
        vin = 12'd2048;
        tick();
        run(2'd3, lat, ta);
        check(lat == 16, "R2 external latency", lat, 16);
        check(code == 12'd2048, "R2 external code", code, 2048);
        clear_done();
        idle_check(30, "R2 held level no retrigger");
        ext_start = 1'b0;
        idle_check(5, "R2 falling edge ignored");

        // Start while busy (R10)
        src_sel = 2'd0;
        vin = 12'd500;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        repeat (5) tick();
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        while (!done) tick();
        check(code == 12'd500, "R10 first result", code, 500);
        idle_check(20, "R10 busy start ignored");

        // Sticky done and irq (R8, R9)
        repeat (10) tick();
        check(done, "R8 done sticky", done, 1);
        check(!irq, "R9 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq, "R9 irq raised", irq, 1);
        clear_done();
        check(!done && !irq, "R8 done cleared", {done, irq}, 0);
        // Completion wins over simultaneous clear
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        repeat (12) tick();
        done_clr = 1'b1; tick(); done_clr = 1'b0;
        check(done, "R8 set wins over clear", done, 1);
        clear_done();
        irq_en = 1'b0;

        // SAR enable freezes (R11)
        ce_off = 1'b1;
        tick();
        vin = 12'd3000;
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        repeat (30) tick();
        check(busy && !done, "R11 frozen without enable", {busy, done}, 2);
        ce_off = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin tick(); lat++; end
        check(done && code == 12'd3000, "R11 resumes", code, 3000);
        clear_done();
        ce_alt = 1'b1;
        vin = 12'd1365;
        run(2'd0, lat, ta);
        check(code == 12'd1365, "R11 alternating enable code", code, 1365);
        check(lat > 20, "R11 slower with gated enable", lat, 21);
        ce_alt = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule